// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital scheduler that sits in front of a multi-channel successive-approximation converter. It watches a sample trigger, an on bit and an enable bit, and issues start strobes to a converter core. The core is modelled inside the block as a fixed latency of `CONV_LAT` clock cycles. A memory-slot pointer selects the channel slot for each conversion. Every conversion that completes normally produces a one-cycle result strobe tagged with its slot index. A conversion that is cut short produces an abort strobe, and its data must be treated as unreliable.

Four operating modes are selected on `mode_i`. Each has its own rule for what happens when the enable bit drops:
- one-shot: a single conversion on one slot.
- sequence: one pass over a run of slots.
- repeated channel: the same slot converted over and over.
- repeated sequence: the run of slots converted over and over.

An option chains conversions back to back after a single trigger. When the reference buffer is in use, the chain inserts a one-cycle gap. Per-slot end markers in `eos_mask_i` close a sequence.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy_o`, `conv_start_o`, `res_valid_o` and `conv_abort_o` are low, and `slot_o` equals `start_addr_i`.
- R2: `mode_i` encodes the modes as 00 one-shot, 01 sequence, 10 repeated channel and 11 repeated sequence. In one-shot mode, a rising edge of `trig_i` while `on_i` and `enc_i` are high converts slot `start_addr_i` once. The result strobe appears `CONV_LAT` cycles after the start strobe, and the block then goes idle.
- R3: In modes 01 and 11 the pointer starts at `start_addr_i` and adds one after each conversion, wrapping from slot 31 to 0. In mode 01 the sequence ends after the slot whose bit in `eos_mask_i` is set. One result strobe is issued per slot, carrying that slot.
- R4: Chaining is active when `msc_i` and `pulse_mode_i` are high and the mode is not 00. One trigger then starts the first conversion. Each following start strobe comes in the same cycle as the previous result strobe. Without `pulse_mode_i` there is no chaining.
- R5: When `refbuf_i` is high, each chained start strobe comes exactly one cycle after the previous result strobe.
- R6: Trigger edges that arrive while a conversion or a chain is running have no effect. In the repeated modes, a new run needs `enc_i` to go low and then high again.
- R7: In mode 00, a low `enc_i` during a conversion aborts it at the next edge. `conv_abort_o` pulses, no result strobe is issued, and `busy_o` is low in the same cycle as the abort pulse.
- R8: In modes 01, 10 and 11 with at least one end marker set, a low `enc_i` lets the running conversion deliver its result and then stops. This also holds when the enable drops in the very cycle the conversion completes.
- R9: In modes 01 and 11 with no end marker set, a low `enc_i` does not stop the run. Switching `mode_i` to 00 while `enc_i` is low aborts it.
- R10: A low `on_i` aborts any mode at the next edge, with an abort pulse.
- R11: In mode 11, the slot after an end-marked slot is `start_addr_i`.
- R12: Without chaining, each conversion after the first waits for a new trigger edge, and `busy_o` stays high between conversions of a sequence.
- R13: `busy_o` rises only together with a start strobe. It stays high until the final conversion's result strobe or abort pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Operating mode (see R2) |
| on_i | input | 1 | Converter on bit |
| enc_i | input | 1 | Conversion enable bit |
| msc_i | input | 1 | Chain conversions after one trigger |
| pulse_mode_i | input | 1 | Sample timer (pulse sample) mode in use |
| refbuf_i | input | 1 | Local reference buffer in use |
| trig_i | input | 1 | Sample trigger; rising edge starts work |
| start_addr_i | input | 5 | First slot of a sequence or the one-shot slot |
| eos_mask_i | input | 32 | End-of-sequence marker per slot |
| busy_o | output | 1 | Operation in progress |
| slot_o | output | 5 | Current slot pointer |
| conv_start_o | output | 1 | One-cycle start strobe to the converter core |
| conv_abort_o | output | 1 | Conversion aborted; data unreliable |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_slot_o | output | 5 | Slot of the completed result |

## Verification
Two events can land on the same clock edge: completion of a conversion, and a stop request through the enable bit or a new chained start. The bench forces them together by waiting for a start strobe and counting `CONV_LAT-1` edges. It then drops `enc_i` just before the completing edge. The expected outcome is exactly one result strobe, no further start and an idle block. In chained runs, the cycle of each result strobe is compared with the cycle of the next start strobe, which must match, or lag by one with the reference buffer in use.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        MD_ONESHOT = 2'b00,
        MD_SEQ     = 2'b01,
        MD_RPT_CH  = 2'b10,
        MD_RPT_SEQ = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_GAP,
        ST_WAIT
    } state_e;
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rise_o
);
    logic trig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_i;
    end

    assign rise_o = trig_i & ~trig_q;
endmodule

// File: rtl/adc_slot_step.sv
module adc_slot_step
    import adc_seq_pkg::*;
#(
    parameter int N_SLOTS = 32,
    localparam int SW = $clog2(N_SLOTS)
) (
    input  mode_e             mode_i,
    input  logic [SW-1:0]     ptr_i,
    input  logic [SW-1:0]     start_i,
    input  logic [N_SLOTS-1:0] eos_mask_i,
    output logic [SW-1:0]     next_o,
    output logic              at_eos_o,
    output logic              any_eos_o
);
    logic [SW-1:0] inc;

    assign at_eos_o  = eos_mask_i[ptr_i];
    assign any_eos_o = |eos_mask_i;
    assign inc = (ptr_i == SW'(N_SLOTS - 1)) ? '0 : ptr_i + 1'b1;

    always_comb begin
        unique case (mode_i)
            MD_SEQ, MD_RPT_SEQ: next_o = at_eos_o ? start_i : inc;
            default:            next_o = ptr_i;
        endcase
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int N_SLOTS  = 32,
    parameter int CONV_LAT = 4,
    localparam int SW = $clog2(N_SLOTS),
    localparam int CW = (CONV_LAT > 1) ? $clog2(CONV_LAT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic               on_i,
    input  logic               enc_i,
    input  logic               msc_i,
    input  logic               pulse_mode_i,
    input  logic               refbuf_i,
    input  logic               trig_i,
    input  logic [SW-1:0]      start_addr_i,
    input  logic [N_SLOTS-1:0] eos_mask_i,
    output logic               busy_o,
    output logic [SW-1:0]      slot_o,
    output logic               conv_start_o,
    output logic               conv_abort_o,
    output logic               res_valid_o,
    output logic [SW-1:0]      res_slot_o
);
    localparam logic [CW-1:0] CNT_LOAD = CW'(CONV_LAT - 1);

    typedef struct packed {
        state_e        st;
        logic [SW-1:0] ptr;
        logic [CW-1:0] cnt;
        logic          start;
        logic          res_v;
        logic [SW-1:0] res_slot;
        logic          abort;
        logic          enc_low;
    } regs_t;

    regs_t r_d, r_q;
    mode_e md;
    logic  rise, at_eos, any_eos;
    logic [SW-1:0] next_ptr;
    logic  chain, go, kill, stop_ok, low_seen, fin;

    assign md = mode_e'(mode_i);

    adc_trig_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .rise_o (rise)
    );

    adc_slot_step #(.N_SLOTS(N_SLOTS)) u_step (
        .mode_i     (md),
        .ptr_i      (r_q.ptr),
        .start_i    (start_addr_i),
        .eos_mask_i (eos_mask_i),
        .next_o     (next_ptr),
        .at_eos_o   (at_eos),
        .any_eos_o  (any_eos)
    );

    always_comb begin
        chain    = msc_i & pulse_mode_i & (md != MD_ONESHOT);
        go       = on_i & enc_i & rise;
        kill     = !on_i || (md == MD_ONESHOT && !enc_i);
        stop_ok  = (md == MD_RPT_CH) || any_eos;
        low_seen = r_q.enc_low | !enc_i;
        unique case (md)
            MD_ONESHOT: fin = 1'b1;
            MD_SEQ:     fin = at_eos || (low_seen && any_eos);
            MD_RPT_CH:  fin = low_seen;
            default:    fin = low_seen && any_eos;
        endcase

        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.res_v = 1'b0;
        r_d.abort = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                r_d.ptr     = start_addr_i;
                r_d.enc_low = 1'b0;
                if (go) begin
                    r_d.st    = ST_CONV;
                    r_d.cnt   = CNT_LOAD;
                    r_d.start = 1'b1;
                end
            end
            ST_CONV: begin
                if (kill) begin
                    r_d.st    = ST_IDLE;
                    r_d.abort = 1'b1;
                    r_d.ptr   = start_addr_i;
                end else if (r_q.cnt != '0) begin
                    r_d.cnt     = r_q.cnt - 1'b1;
                    r_d.enc_low = low_seen;
                end else begin
                    r_d.res_v    = 1'b1;
                    r_d.res_slot = r_q.ptr;
                    r_d.ptr      = next_ptr;
                    r_d.enc_low  = 1'b0;
                    if (fin) begin
                        r_d.st = ST_IDLE;
                    end else if (chain && !refbuf_i) begin
                        r_d.cnt   = CNT_LOAD;
                        r_d.start = 1'b1;
                    end else if (chain) begin
                        r_d.st = ST_GAP;
                    end else begin
                        r_d.st = ST_WAIT;
                    end
                end
            end
            ST_GAP: begin
                if (kill || (!enc_i && stop_ok)) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.st    = ST_CONV;
                    r_d.cnt   = CNT_LOAD;
                    r_d.start = 1'b1;
                end
            end
            default: begin
                if (kill || (!enc_i && stop_ok)) begin
                    r_d.st = ST_IDLE;
                end else if (go) begin
                    r_d.st    = ST_CONV;
                    r_d.cnt   = CNT_LOAD;
                    r_d.start = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.ptr      <= start_addr_i;
            r_q.cnt      <= '0;
            r_q.start    <= 1'b0;
            r_q.res_v    <= 1'b0;
            r_q.res_slot <= '0;
            r_q.abort    <= 1'b0;
            r_q.enc_low  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.st != ST_IDLE);
    assign slot_o       = r_q.ptr;
    assign conv_start_o = r_q.start;
    assign conv_abort_o = r_q.abort;
    assign res_valid_o  = r_q.res_v;
    assign res_slot_o   = r_q.res_slot;

    p_res_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> res_slot_o == $past(r_q.ptr));

    p_oneshot_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && $past(mode_i) == 2'b00) |-> !busy_o);

    p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort_o |-> (!busy_o && !res_valid_o));

    p_power_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !on_i) |=> !busy_o);

    p_busy_rise_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> conv_start_o);
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        on_i = 1'b1, enc_i = 1'b0, msc_i = 1'b0, pulse_mode_i = 1'b1;
    logic        refbuf_i = 1'b0, trig_i = 1'b0;
    logic [4:0]  start_addr_i = 5'd9;
    logic [31:0] eos_mask_i = '0;
    logic        busy_o, conv_start_o, conv_abort_o, res_valid_o;
    logic [4:0]  slot_o, res_slot_o;

    adc_seq_ctrl #(.N_SLOTS(32), .CONV_LAT(LAT)) dut (.*);

    always #4 clk = ~clk;

    int cyc = 0, n_res = 0, n_start = 0, n_abort = 0, checks = 0, fails = 0;
    int first_start_cyc = 0, last_res_cyc = 0;
    logic [4:0] res_log [0:1023];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (conv_start_o) begin
            if (n_start == 0) first_start_cyc = cyc;
            n_start = n_start + 1;
        end
        if (res_valid_o) begin
            res_log[n_res & 1023] = res_slot_o;
            n_res = n_res + 1;
            last_res_cyc = cyc;
        end
        if (conv_abort_o) n_abort = n_abort + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk); #1;
        n_res = 0; n_start = 0; n_abort = 0;
    endtask

    task automatic pulse_trig();
        @(negedge clk) trig_i = 1'b1;
        @(negedge clk) trig_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            if (!busy_o) break;
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    typedef struct packed {
        logic [1:0] mode;
        logic       refbuf;
        logic [4:0] start;
        logic [4:0] eos;
        logic [5:0] n_exp;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'b00, 1'b0, 5'd7,  5'd0,  6'd1},
        '{2'b01, 1'b0, 5'd3,  5'd6,  6'd4},
        '{2'b01, 1'b1, 5'd3,  5'd6,  6'd4},
        '{2'b01, 1'b0, 5'd30, 5'd1,  6'd4},
        '{2'b01, 1'b1, 5'd12, 5'd12, 6'd1}
    };

    initial begin
        repeat (400000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        cycles(3);
        chk(!busy_o && !conv_start_o && !res_valid_o && !conv_abort_o, "R1 idle outputs", busy_o, 0);
        chk(slot_o == 5'd9, "R1 slot = start", slot_o, 9);
        @(negedge clk) rst_n = 1'b1;
        cycles(2);
        chk(!busy_o && slot_o == 5'd9, "R1 after release", slot_o, 9);

        // table walk: R2 R3 R4 R5 R6
        foreach (VECS[k]) begin
            mode_i = VECS[k].mode; refbuf_i = VECS[k].refbuf;
            start_addr_i = VECS[k].start; eos_mask_i = 32'd1 << VECS[k].eos;
            msc_i = 1'b1; pulse_mode_i = 1'b1; enc_i = 1'b1; on_i = 1'b1;
            clear_log();
            pulse_trig();
            cycles(2);
            pulse_trig(); // R6 ignored mid-run
            wait_idle();
            cycles(LAT + 2);
            chk(n_res == VECS[k].n_exp, "R3/R6 result count", n_res, VECS[k].n_exp);
            chk(res_log[0] == VECS[k].start, "R2/R3 first slot", res_log[0], VECS[k].start);
            if (VECS[k].mode != 2'b00)
                chk(res_log[n_res-1] == VECS[k].eos, "R3 last slot", res_log[n_res-1], VECS[k].eos);
            for (int j = 1; j < n_res; j++)
                chk(res_log[j] == 5'(res_log[j-1] + 1), "R3 slot step", res_log[j], res_log[j-1] + 1);
            chk(last_res_cyc - first_start_cyc == VECS[k].n_exp * LAT + (VECS[k].refbuf ? VECS[k].n_exp - 1 : 0),
                "R4/R5 chain timing", last_res_cyc - first_start_cyc,
                VECS[k].n_exp * LAT + (VECS[k].refbuf ? VECS[k].n_exp - 1 : 0));
            enc_i = 1'b0;
            cycles(1);
        end

        // R7 one-shot abort
        mode_i = 2'b00; start_addr_i = 5'd5; enc_i = 1'b1; refbuf_i = 1'b0;
        clear_log();
        pulse_trig();
        cycles(1);
        enc_i = 1'b0;
        cycles(1);
        chk(n_abort == 1 && !busy_o, "R7 abort pulse", n_abort, 1);
        cycles(LAT + 2);
        chk(n_res == 0, "R7 no result", n_res, 0);

        // R8 R6 repeated channel chained
        mode_i = 2'b10; start_addr_i = 5'd20; msc_i = 1'b1; enc_i = 1'b1;
        clear_log();
        pulse_trig();
        cycles(3 * LAT + 2);
        chk(n_res >= 3 && res_log[0] == 5'd20 && res_log[2] == 5'd20, "R3/R4 repeat slot", res_log[2], 20);
        begin
            int k0;
            pulse_trig(); // R6
            @(negedge clk) enc_i = 1'b0;
            #1 k0 = n_res;
            wait_idle();
            cycles(LAT + 2);
            chk(n_res == k0 + 1, "R8 finish current", n_res, k0 + 1);
            chk(!busy_o, "R8 halted", busy_o, 0);
        end
        @(negedge clk) enc_i = 1'b1;
        clear_log();
        pulse_trig();
        cycles(1);
        chk(busy_o && n_start == 1, "R6 restart after toggle", n_start, 1);
        @(negedge clk) enc_i = 1'b0;
        wait_idle();

        // R8 enable drop in the completing cycle
        mode_i = 2'b10; msc_i = 1'b1; enc_i = 1'b1;
        clear_log();
        @(negedge clk) trig_i = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            if (conv_start_o) break;
        end
        trig_i = 1'b0;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk) enc_i = 1'b0;
        cycles(LAT + 3);
        chk(n_res == 1 && n_start == 1, "R8 same-cycle stop results", n_res, 1);
        chk(!busy_o, "R8 same-cycle stop idle", busy_o, 0);

        // R11 repeated sequence wrap to start
        mode_i = 2'b11; start_addr_i = 5'd10; eos_mask_i = 32'd1 << 12; enc_i = 1'b1;
        clear_log();
        pulse_trig();
        cycles(5 * LAT + 2);
        chk(res_log[2] == 5'd12 && res_log[3] == 5'd10 && res_log[4] == 5'd11,
            "R11 return to start", res_log[3], 10);
        enc_i = 1'b0;
        wait_idle();
        chk(!busy_o, "R8 repeated sequence stops", busy_o, 0);

        // R9 no end marker
        mode_i = 2'b11; start_addr_i = 5'd0; eos_mask_i = '0; enc_i = 1'b1;
        clear_log();
        pulse_trig();
        cycles(LAT);
        enc_i = 1'b0;
        begin
            int k1;
            cycles(2 * LAT);
            k1 = n_res;
            cycles(4 * LAT);
            chk(busy_o && n_res > k1, "R9 keeps running", n_res, k1 + 1);
        end
        @(negedge clk) mode_i = 2'b00;
        cycles(2);
        chk(!busy_o, "R9 stop via mode 00", busy_o, 0);

        // R10 on bit off
        mode_i = 2'b01; start_addr_i = 5'd0; eos_mask_i = 32'd1 << 31; enc_i = 1'b1; on_i = 1'b1;
        clear_log();
        pulse_trig();
        cycles(LAT + 1);
        on_i = 1'b0;
        cycles(2);
        chk(!busy_o && n_abort == 1, "R10 power-off abort", n_abort, 1);
        on_i = 1'b1; enc_i = 1'b0;
        cycles(2);

        // R12 no chaining (pulse mode off, chaining flag on)
        mode_i = 2'b01; start_addr_i = 5'd4; eos_mask_i = 32'd1 << 6;
        msc_i = 1'b1; pulse_mode_i = 1'b0; enc_i = 1'b1;
        clear_log();
        pulse_trig();
        cycles(3 * LAT);
        chk(n_res == 1 && busy_o, "R12 waits for trigger", n_res, 1);
        pulse_trig();
        cycles(2 * LAT);
        chk(n_res == 2 && res_log[1] == 5'd5 && busy_o, "R12 second slot", res_log[1], 5);
        pulse_trig();
        cycles(2 * LAT);
        chk(n_res == 3 && !busy_o, "R12 sequence end", n_res, 3);
        chk(n_start == 3, "R13 one start per result", n_start, 3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule